// File: doc/BRIEF.md
# Cascadable Dual Pulse Accumulator

This block holds two 8-bit counters that count rising edges on two pulse input pins. The first pin also drives a capture channel, and the block passes that pin's synchronised level on to the capture channel. Each pin passes through a two-stage synchroniser before any edge is detected. In separate mode each counter counts only its own pin, and only while its own enable bit is set.

A single cascade bit joins the two counters into one 16-bit accumulator. The accumulator counts rising edges of the first pin. The lower byte carries into the upper byte. In this mode the per-counter enables and the second pin have no effect. An overflow flag records each wrap of the 16-bit value. A separate enable bit gates the flag onto an interrupt request line. The accumulator ignores the main timer's enable input.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. Software can load either count byte directly, and clears the flag by writing 1 to it.

Top module: `pulse_accum_pair`

## Requirements
- R1: With the cascade bit set, the two count registers form one 16-bit value {high,low}. The low byte wraps from 0xFF to 0x00 and adds one to the high byte in the same clock.
- R2: With the cascade bit set, the low counter increments on every rising edge of `pulse_a_pin`, whatever the per-counter enables hold. Edges on `pulse_b_pin` change nothing.
- R3: With the cascade bit clear, the low counter counts `pulse_a_pin` edges only while its enable is set. The high counter counts `pulse_b_pin` edges only while its enable is set. A low-byte wrap does not touch the high byte.
- R4: Each pin passes through two flip-flops before edge detection. `cap0_level` follows `pulse_a_pin` two clocks later. A rising edge on a pin changes the count on the third rising clock edge after the pin rises, by exactly one.
- R5: The overflow flag sets when the cascaded 16-bit value goes from 0xFFFF to 0x0000.
- R6: `ovf_irq` is high exactly while both the overflow flag and the interrupt enable bit are set.
- R7: `timer_en` has no effect on counting or on any register.
- R8: The register map is: address 0 is control, address 1 is the low count, address 2 is the high count, and address 3 reads zero. Control bit 0 is the low enable, bit 1 the high enable, bit 2 cascade, bit 3 interrupt enable, and bit 4 the overflow flag; bits 7:5 read zero. Every register resets to zero. Control can be written and read back at any time.
- R9: Writing control with bit 4 set clears the overflow flag. Writing with bit 4 clear leaves the flag as it was. If an overflow happens in the same cycle as a clearing write, the flag ends up set.
- R10: A write to address 1 or 2 loads that byte. If the same byte would also increment in that cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| pulse_a_pin | input | 1 | Pulse pin A, shared with capture channel 0 |
| pulse_b_pin | input | 1 | Pulse pin B |
| timer_en | input | 1 | Main timer enable, ignored by this block |
| cap0_level | output | 1 | Synchronised pin A level for the capture channel |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench preloads 0xFFFF and sends one edge, then checks that the count wraps to zero and that the flag sets. A design that skipped the carry, or took the flag from the low byte, would show a wrong high byte or a flag that never sets. It lines up an overflow with a clearing write in the same cycle, and a count write with an increment in the same cycle. A design with the wrong priority would lose the flag, or would end one count above the written value. It also sends edges on pin B and sets the per-counter enables while in cascade mode, which catches a design that lets separate-mode controls leak into the 16-bit counter.

// File: rtl/pacc_pkg.sv
// Shared constants for the dual pulse accumulator: register addresses and
// control bit positions. Assumes a 2-bit register address space.
package pacc_pkg;
    localparam int ADDR_W  = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LOW  = 2'd1;
    localparam logic [ADDR_W-1:0] A_HIGH = 2'd2;
    localparam int B_LO_EN  = 0;
    localparam int B_HI_EN  = 1;
    localparam int B_CASC   = 2;
    localparam int B_IE     = 3;
    localparam int B_FLAG   = 4;
endpackage

// File: rtl/pacc_sync_edge.sv
// Synchronises one asynchronous pin through STAGES flip-flops and flags a
// one-cycle pulse on each rising edge of the synchronised level.
// Assumes STAGES >= 2.
module pacc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the pin into the synchroniser chain and remember the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            last  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~last;

    // R4: an edge pulse never lasts two cycles
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pacc_byte_counter.sv
// One counter byte with a direct load port. A load beats an increment in the
// same cycle. wrap reports an increment that rolls the byte from all-ones to zero.
module pacc_byte_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    // Hold, load or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (inc)
            count <= count + 1'b1;
    end

    assign wrap = inc && !load && (count == '1);

    // R10: a load always wins
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    // R1: an increment moves the byte by exactly one, modulo 2^W
    assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> count == W'($past(count) + 1'b1));
endmodule

// File: rtl/pacc_ctrl.sv
// Control register: per-counter enables, cascade, interrupt enable and the
// sticky overflow flag. A write with the flag bit set clears the flag, and a
// set in the same cycle overrides that clear.
module pacc_ctrl
    import pacc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          set_ovf,
    output logic          lo_en,
    output logic          hi_en,
    output logic          casc,
    output logic          ie,
    output logic          flag
);
    // Load the enable bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_en <= 1'b0;
            hi_en <= 1'b0;
            casc  <= 1'b0;
            ie    <= 1'b0;
        end else if (wr) begin
            lo_en <= wdata[B_LO_EN];
            hi_en <= wdata[B_HI_EN];
            casc  <= wdata[B_CASC];
            ie    <= wdata[B_IE];
        end
    end

    // Sticky overflow flag, where a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_ovf)
            flag <= 1'b1;
        else if (wr && wdata[B_FLAG])
            flag <= 1'b0;
    end

    // R9: a set is never lost
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf |=> flag);
    // R9: a clearing write without a set empties the flag
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[B_FLAG] && !set_ovf) |=> !flag);
endmodule

// File: rtl/pulse_accum_pair.sv
// Two edge-counting byte accumulators that can be cascaded into one 16-bit
// counter on pin A. Provides a register port, a synchronised pin A level
// for the capture channel, and a gated overflow interrupt. timer_en is
// accepted but has no effect.
module pulse_accum_pair
    import pacc_pkg::*;
#(
    parameter int CW     = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW-1:0]     rd_data,
    input  logic              pulse_a_pin,
    input  logic              pulse_b_pin,
    input  logic              timer_en,
    output logic              cap0_level,
    output logic              ovf_irq
);
    localparam int NCH = 2;

    logic [NCH-1:0] pins, levels, rises;
    logic lo_en, hi_en, casc, ie, flag;
    logic lo_inc, hi_inc, lo_wrap, hi_wrap, set_ovf;
    logic [CW-1:0] lo_cnt, hi_cnt;

    assign pins = {pulse_b_pin, pulse_a_pin};

    for (genvar i = 0; i < NCH; i++) begin : g_sync
        pacc_sync_edge #(.STAGES(STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin(pins[i]),
            .level(levels[i]), .rise(rises[i]));
    end

    pacc_ctrl #(.DW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_en && wr_addr == A_CTRL), .wdata(wr_data),
        .set_ovf(set_ovf),
        .lo_en(lo_en), .hi_en(hi_en), .casc(casc), .ie(ie), .flag(flag));

    // Increment selection: in cascade mode the high byte takes the low carry.
    always_comb begin
        lo_inc = rises[0] && (casc || lo_en);
        hi_inc = casc ? lo_wrap : (rises[1] && hi_en);
    end

    pacc_byte_counter #(.W(CW)) u_low (
        .clk(clk), .rst_n(rst_n), .inc(lo_inc),
        .load(wr_en && wr_addr == A_LOW), .load_val(wr_data),
        .count(lo_cnt), .wrap(lo_wrap));

    pacc_byte_counter #(.W(CW)) u_high (
        .clk(clk), .rst_n(rst_n), .inc(hi_inc),
        .load(wr_en && wr_addr == A_HIGH), .load_val(wr_data),
        .count(hi_cnt), .wrap(hi_wrap));

    assign set_ovf    = casc && hi_wrap;
    assign ovf_irq    = flag && ie;
    assign cap0_level = levels[0];

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[B_LO_EN] = lo_en;
                rd_data[B_HI_EN] = hi_en;
                rd_data[B_CASC]  = casc;
                rd_data[B_IE]    = ie;
                rd_data[B_FLAG]  = flag;
            end
            A_LOW:   rd_data = lo_cnt;
            A_HIGH:  rd_data = hi_cnt;
            default: rd_data = '0;
        endcase
    end

    // R7: a change on timer_en alone never moves the counts
    assert_timer_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_en != $past(timer_en)) && !rises[0] && !rises[1] && !wr_en
        |=> $stable({hi_cnt, lo_cnt}));
    // R2: in cascade mode pin B never moves the high byte by itself
    assert_b_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        casc && !lo_wrap && !wr_en |=> $stable(hi_cnt));
    // R5: the cascaded counter leaves 0xFFFF to zero and raises the flag
    assert_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && lo_inc && !wr_en && lo_cnt == '1 && hi_cnt == '1)
        |=> flag && lo_cnt == '0 && hi_cnt == '0);
    // R6: no request while the enable is clear
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !ovf_irq);
endmodule

// File: tb/pulse_accum_pair_test.sv
module pulse_accum_pair_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic pa = 1'b0, pb = 1'b0, timer_en = 1'b0;
    logic cap0_level, ovf_irq;
    int errors = 0, checks = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    pulse_accum_pair uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pulse_a_pin(pa), .pulse_b_pin(pb), .timer_en(timer_en),
        .cap0_level(cap0_level), .ovf_irq(ovf_irq));

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] pre_lo;
        logic [7:0] pre_hi;
        logic [3:0] na;
        logic [3:0] nb;
        logic [7:0] exp_lo;
        logic [7:0] exp_hi;
    } vec_t;

    // ctrl, preload lo/hi, pin A edges, pin B edges, expected lo/hi
    localparam vec_t VECS [8] = '{
        '{8'h01, 8'h00, 8'h00, 4'd3, 4'd2, 8'h03, 8'h00},  // R3 low only
        '{8'h02, 8'h00, 8'h00, 4'd3, 4'd2, 8'h00, 8'h02},  // R3 high only
        '{8'h03, 8'h00, 8'h00, 4'd5, 4'd4, 8'h05, 8'h04},  // R3 both
        '{8'h04, 8'h00, 8'h00, 4'd3, 4'd5, 8'h03, 8'h00},  // R2 cascade, B ignored
        '{8'h07, 8'h00, 8'h00, 4'd2, 4'd2, 8'h02, 8'h00},  // R2 enables no effect
        '{8'h00, 8'h00, 8'h00, 4'd2, 4'd2, 8'h00, 8'h00},  // R3 all off
        '{8'h04, 8'hFE, 8'h12, 4'd3, 4'd0, 8'h01, 8'h13},  // R1 carry
        '{8'h01, 8'hFF, 8'h05, 4'd1, 4'd0, 8'h00, 8'h05}   // R3 no carry
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic pulse(input bit on_b);
        @(negedge clk);
        if (on_b) pb = 1'b1; else pa = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        if (on_b) pb = 1'b0; else pa = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    // Pin A edge whose count step coincides with a register write.
    task automatic timed_pulse(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        pa = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        pa = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R8 reset", v, 8'h00);
        end
        check("R6 reset irq", {7'b0, ovf_irq}, 8'h00);

        // R8 control readback, upper bits read zero
        wr(2'd0, 8'hEF);
        rd(2'd0, v);
        check("R8 ctrl readback", v, 8'h0F);
        rd(2'd3, v);
        check("R8 unused address", v, 8'h00);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, 8'h00);
            wr(2'd1, VECS[i].pre_lo);
            wr(2'd2, VECS[i].pre_hi);
            wr(2'd0, VECS[i].ctrl);
            for (int k = 0; k < int'(VECS[i].na); k++) pulse(1'b0);
            for (int k = 0; k < int'(VECS[i].nb); k++) pulse(1'b1);
            rd(2'd1, v);
            check($sformatf("R1/R2/R3 vec%0d low", i), v, VECS[i].exp_lo);
            rd(2'd2, v);
            check($sformatf("R1/R2/R3 vec%0d high", i), v, VECS[i].exp_hi);
        end

        // R4 synchroniser latency and capture level
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h20);
        @(negedge clk);
        pa = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R4 cap0 after one clock", {7'b0, cap0_level}, 8'h00);
        @(posedge clk);
        @(negedge clk);
        check("R4 cap0 after two clocks", {7'b0, cap0_level}, 8'h01);
        rd_addr = 2'd1; #1;
        check("R4 count before third edge", rd_data, 8'h20);
        @(posedge clk);
        @(negedge clk);
        check("R4 count at third edge", rd_data, 8'h21);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 single step per edge", rd_data, 8'h21);
        pa = 1'b0;
        repeat (4) @(posedge clk);

        // R5/R6/R7 overflow with timer enable toggled
        timer_en = 1'b1;
        wr(2'd0, 8'h0C);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        pulse(1'b0);
        timer_en = 1'b0;
        rd(2'd1, v);
        check("R5/R7 wrap low", v, 8'h00);
        rd(2'd2, v);
        check("R5/R7 wrap high", v, 8'h00);
        rd(2'd0, v);
        check("R5 flag set", v, 8'h1C);
        check("R6 irq raised", {7'b0, ovf_irq}, 8'h01);
        wr(2'd0, 8'h04);
        check("R6 irq masked", {7'b0, ovf_irq}, 8'h00);
        rd(2'd0, v);
        check("R9 flag kept by zero write", v, 8'h14);
        wr(2'd0, 8'h1C);
        rd(2'd0, v);
        check("R9 flag cleared", v, 8'h0C);
        check("R6 irq after clear", {7'b0, ovf_irq}, 8'h00);

        // R9 set wins over a same-cycle clear
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        timed_pulse(2'd0, 8'h1C);
        rd(2'd0, v);
        check("R9 set beats clear", v, 8'h1C);

        // R10 write beats a same-cycle increment
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h10);
        timed_pulse(2'd1, 8'h40);
        rd(2'd1, v);
        check("R10 write beats increment", v, 8'h40);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule